// File: doc/BRIEF.md
# Leakage-Minimizing Body Bias Search Controller

This controller finds the reverse body bias setting at which a reference device leaks least. It does not read a current. It times how long the leaking device takes to pull a monitored node away from its preset level. Each measurement first presets the node through the `precharge` output and then releases it. The controller samples the synchronized `node_in` once per sampling period and counts the periods that pass before the node is seen to have flipped. A longer time means less leakage, so a larger count marks a better bias point.

A `start` pulse launches a search. The search begins at a bias code where leakage still falls as reverse bias grows. It raises the code one step per measurement and stops at the first step whose count is smaller than the count of the step before. The earlier step is then reported as the optimum. The controller also keeps the count inside a usable window. It picks the capacitor bank size and a small gate-bias boost, and every change of range starts the search again from the initial code, so that all compared counts come from the same range. The `mode_chg` input selects whether the node is precharged high and discharges, or is preset low and charges.

Top module: `bias_search_ctrl`

## Requirements
- R1: Each measurement holds `precharge` high for exactly PRE_CYC (default 4) cycles, then releases it. `node_in` is then sampled once every SAMPLE_DIV (default 2) cycles.
- R2: `node_in` passes through a two-flop synchronizer. The measured count is the number of whole sampling periods that elapse before a sample sees the node flipped, so for a flip T cycles after release the count is about T/SAMPLE_DIV.
- R3: With `mode_chg`=0 the node is precharged high and is flipped when it reads 0. With `mode_chg`=1 the node is preset low and is flipped when it reads 1.
- R4: A search starts at code INIT_CODE (default 0) and raises `bias_code` by exactly one after each accepted measurement. A larger count is treated as lower leakage.
- R5: The search ends at the first step whose count is strictly below the previous step's count. `bias_code` returns to the previous code and `best_count` holds that code's count. Equal counts do not end the search.
- R6: Range level L runs from 0 (slowest) to 2^CAP_W (fastest). For L < 2^CAP_W, `cap_sel` = 2^CAP_W-1-L and `gbias_en` = 0. For L = 2^CAP_W, `cap_sel` = 0 and `gbias_en` = 1. Each start sets L to INIT_LEVEL (default 1, giving `cap_sel`=2). A measurement that saturates at the all-ones count moves L one step faster.
- R7: A count below MIN_CNT (default 10) moves L one step slower. Once L has moved in one direction during a search, it never moves in the other direction in that search. At either end of the range the count is accepted as it stands.
- R8: Every range change restarts the search at INIT_CODE and forgets the previous count. The range does not change otherwise.
- R9: If the code reaches its maximum (all ones) without a rise in leakage, the search ends there with `limit`=1. Otherwise `limit`=0.
- R10: `done` is high for exactly one cycle when a search ends. `bias_code`, `cap_sel`, `gbias_en`, `limit` and `best_count` then hold until the next start. A `start` during a search is ignored.
- R11: After reset `precharge`=0, `done`=0, `limit`=0, `best_count`=0, `bias_code`=INIT_CODE, and the range is at INIT_LEVEL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that launches a search |
| mode_chg | input | 1 | 0: node discharges from high; 1: node charges from low |
| node_in | input | 1 | Asynchronous monitored node level |
| precharge | output | 1 | Presets the monitored node while high |
| cap_sel | output | CAP_W | Capacitor bank select, larger is slower |
| gbias_en | output | 1 | Gate-bias boost that speeds the node |
| bias_code | output | CODE_W | Digital body-bias setting |
| done | output | 1 | One-cycle end-of-search pulse |
| limit | output | 1 | Search reached the maximum code |
| best_count | output | CNT_W | Count measured at the chosen code |

## Verification
The assertions check every cycle that `done` lasts one cycle and that results stay frozen while idle. They also check that the code moves only by single steps or back to the initial code, that a range change always coincides with a restart at the initial code, that a limit end reports the maximum code, and that the meter is never asked to start while it is busy. Only the bench's scenarios can show that the correct optimum is chosen from node timing. The same holds for both node polarities, for range adaptation towards faster and slower settings including the gate boost, and for the counts matching the modelled discharge time.

// File: rtl/bsc_pkg.sv
// Shared state types for the body bias search controller.
package bsc_pkg;
    typedef enum logic [1:0] {M_IDLE, M_PRE, M_RUN} meter_st_t;
    typedef enum logic {S_IDLE, S_WAIT} search_st_t;
endpackage

// File: rtl/bsc_sync.sv
// Two-flop synchronizer for the asynchronous monitored node.
// Assumes the input is a level that stays stable for several cycles.
module bsc_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    logic meta_q;
    logic sync_q;

    // Two sampling stages to resolve metastability (R2).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign d_sync = sync_q;
endmodule

// File: rtl/bsc_meter.sv
// One leakage measurement: presets the node, releases it and counts the
// sampling periods until the synchronized node reads flipped.
// Assumes PRE_CYC >= 3 so the synchronizer has flushed before counting.
module bsc_meter
    import bsc_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int PRE_CYC    = 4,
    parameter int SAMPLE_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             mode_chg,
    input  logic             node_s,
    output logic             precharge,
    output logic             rdy,
    output logic [CNT_W-1:0] count,
    output logic             sat
);
    localparam int PW = $clog2(PRE_CYC + 1);
    localparam int DW = $clog2(SAMPLE_DIV + 1);
    localparam logic [PW-1:0]    PRE_LAST = PW'(PRE_CYC - 1);
    localparam logic [DW-1:0]    DIV_LAST = DW'(SAMPLE_DIV - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    meter_st_t        st;
    logic [PW-1:0]    pre_cnt;
    logic [DW-1:0]    div_cnt;
    logic [CNT_W-1:0] per_cnt;
    logic             flipped;

    // Polarity of a finished node: low when discharging, high when charging (R3).
    always_comb flipped = mode_chg ? node_s : ~node_s;

    // Measurement sequencer: preset, release, periodic sampling (R1, R2).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= M_IDLE;
            pre_cnt <= '0;
            div_cnt <= '0;
            per_cnt <= '0;
            rdy     <= 1'b0;
            count   <= '0;
            sat     <= 1'b0;
        end else begin
            rdy <= 1'b0;
            case (st)
                M_IDLE: begin
                    if (go) begin
                        st      <= M_PRE;
                        pre_cnt <= '0;
                    end
                end
                M_PRE: begin
                    if (pre_cnt == PRE_LAST) begin
                        st      <= M_RUN;
                        div_cnt <= '0;
                        per_cnt <= '0;
                    end else begin
                        pre_cnt <= pre_cnt + PW'(1);
                    end
                end
                M_RUN: begin
                    if (div_cnt == DIV_LAST) begin
                        div_cnt <= '0;
                        if (flipped) begin
                            rdy   <= 1'b1;
                            count <= per_cnt;
                            sat   <= 1'b0;
                            st    <= M_IDLE;
                        end else if (per_cnt == CNT_MAX) begin
                            rdy   <= 1'b1;
                            count <= CNT_MAX;
                            sat   <= 1'b1;
                            st    <= M_IDLE;
                        end else begin
                            per_cnt <= per_cnt + CNT_W'(1);
                        end
                    end else begin
                        div_cnt <= div_cnt + DW'(1);
                    end
                end
                default: st <= M_IDLE;
            endcase
        end
    end

    assign precharge = (st == M_PRE);

    // R1: the search never requests a measurement while one is running.
    a_r1_go_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> st == M_IDLE);
    // R1: a result is only reported after the node has been released.
    a_r1_rdy_released: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> !precharge && !$past(precharge));
    // R6: a saturated result always carries the full-scale count.
    a_r6_sat_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && sat) |-> count == CNT_MAX);
endmodule

// File: rtl/bsc_search.sv
// Hill-climbing search over the bias code with automatic range selection.
// Assumes one measurement result per request from the meter.
module bsc_search
    import bsc_pkg::*;
#(
    parameter int CODE_W     = 4,
    parameter int CNT_W      = 8,
    parameter int CAP_W      = 2,
    parameter int MIN_CNT    = 10,
    parameter int INIT_CODE  = 0,
    parameter int INIT_LEVEL = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              meas_rdy,
    input  logic [CNT_W-1:0]  meas_cnt,
    input  logic              meas_sat,
    output logic              meas_go,
    output logic [CODE_W-1:0] bias_code,
    output logic [CAP_W-1:0]  cap_sel,
    output logic              gbias_en,
    output logic              done,
    output logic              limit,
    output logic [CNT_W-1:0]  best_count
);
    localparam int NCAP  = 1 << CAP_W;
    localparam int LVL_W = $clog2(NCAP + 1);
    localparam logic [LVL_W-1:0]  LVL_TOP  = LVL_W'(NCAP);
    localparam logic [LVL_W-1:0]  LVL_INIT = LVL_W'(INIT_LEVEL);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [CODE_W-1:0] CODE_INI = CODE_W'(INIT_CODE);
    localparam logic [CNT_W-1:0]  CNT_MIN  = CNT_W'(MIN_CNT);

    search_st_t       st;
    logic [LVL_W-1:0] level;
    logic             moved_up;
    logic             moved_dn;
    logic             have_prev;
    logic [CNT_W-1:0] prev_cnt;
    logic             need_up;
    logic             need_dn;

    // Range decisions: saturation speeds up, a short count slows down (R6, R7).
    always_comb begin
        need_up = meas_sat && (level < LVL_TOP) && !moved_dn;
        need_dn = !meas_sat && (meas_cnt < CNT_MIN) && (level != '0) && !moved_up;
    end

    // Range level to capacitor select and gate boost (R6).
    always_comb begin
        if (level < LVL_TOP) begin
            cap_sel  = CAP_W'(NCAP - 1) - CAP_W'(level);
            gbias_en = 1'b0;
        end else begin
            cap_sel  = '0;
            gbias_en = 1'b1;
        end
    end

    // Search sequencer: restart on range change, climb, stop on rise (R4-R10).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= S_IDLE;
            bias_code  <= CODE_INI;
            level      <= LVL_INIT;
            moved_up   <= 1'b0;
            moved_dn   <= 1'b0;
            have_prev  <= 1'b0;
            prev_cnt   <= '0;
            best_count <= '0;
            done       <= 1'b0;
            limit      <= 1'b0;
            meas_go    <= 1'b0;
        end else begin
            done    <= 1'b0;
            meas_go <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (start) begin
                        bias_code <= CODE_INI;
                        level     <= LVL_INIT;
                        moved_up  <= 1'b0;
                        moved_dn  <= 1'b0;
                        have_prev <= 1'b0;
                        limit     <= 1'b0;
                        meas_go   <= 1'b1;
                        st        <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (meas_rdy) begin
                        if (need_up) begin
                            level     <= level + LVL_W'(1);
                            moved_up  <= 1'b1;
                            bias_code <= CODE_INI;
                            have_prev <= 1'b0;
                            meas_go   <= 1'b1;
                        end else if (need_dn) begin
                            level     <= level - LVL_W'(1);
                            moved_dn  <= 1'b1;
                            bias_code <= CODE_INI;
                            have_prev <= 1'b0;
                            meas_go   <= 1'b1;
                        end else if (have_prev && (meas_cnt < prev_cnt)) begin
                            bias_code  <= bias_code - CODE_W'(1);
                            best_count <= prev_cnt;
                            done       <= 1'b1;
                            st         <= S_IDLE;
                        end else if (bias_code == CODE_MAX) begin
                            best_count <= meas_cnt;
                            limit      <= 1'b1;
                            done       <= 1'b1;
                            st         <= S_IDLE;
                        end else begin
                            prev_cnt  <= meas_cnt;
                            have_prev <= 1'b1;
                            bias_code <= bias_code + CODE_W'(1);
                            meas_go   <= 1'b1;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R10: end-of-search pulse lasts a single cycle.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: results stay frozen while idle and no start arrives.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && !start) |=> $stable(bias_code) && $stable(level)
            && $stable(limit) && $stable(best_count));
    // R4: the code only moves by one step or back to the initial code.
    a_r4_code_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bias_code) |-> (bias_code == $past(bias_code) + CODE_W'(1))
            || (bias_code == $past(bias_code) - CODE_W'(1))
            || (bias_code == CODE_INI));
    // R8: a range change always comes with a restart at the initial code.
    a_r8_range_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level) |-> bias_code == CODE_INI);
    // R9: a limit end reports the maximum code.
    a_r9_limit_max: assert property (@(posedge clk) disable iff (!rst_n)
        (done && limit) |-> bias_code == CODE_MAX);
endmodule

// File: rtl/bias_search_ctrl.sv
// Top level: synchronizer, discharge-time meter and bias search.
// Assumes an external monitor node and bias generator that follow the outputs.
module bias_search_ctrl #(
    parameter int CODE_W     = 4,
    parameter int CNT_W      = 8,
    parameter int CAP_W      = 2,
    parameter int PRE_CYC    = 4,
    parameter int SAMPLE_DIV = 2,
    parameter int MIN_CNT    = 10,
    parameter int INIT_CODE  = 0,
    parameter int INIT_LEVEL = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_chg,
    input  logic              node_in,
    output logic              precharge,
    output logic [CAP_W-1:0]  cap_sel,
    output logic              gbias_en,
    output logic [CODE_W-1:0] bias_code,
    output logic              done,
    output logic              limit,
    output logic [CNT_W-1:0]  best_count
);
    logic             node_s;
    logic             meas_go;
    logic             meas_rdy;
    logic [CNT_W-1:0] meas_cnt;
    logic             meas_sat;

    bsc_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (node_in),
        .d_sync  (node_s)
    );

    bsc_meter #(
        .CNT_W      (CNT_W),
        .PRE_CYC    (PRE_CYC),
        .SAMPLE_DIV (SAMPLE_DIV)
    ) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (meas_go),
        .mode_chg  (mode_chg),
        .node_s    (node_s),
        .precharge (precharge),
        .rdy       (meas_rdy),
        .count     (meas_cnt),
        .sat       (meas_sat)
    );

    bsc_search #(
        .CODE_W     (CODE_W),
        .CNT_W      (CNT_W),
        .CAP_W      (CAP_W),
        .MIN_CNT    (MIN_CNT),
        .INIT_CODE  (INIT_CODE),
        .INIT_LEVEL (INIT_LEVEL)
    ) u_search (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .meas_rdy   (meas_rdy),
        .meas_cnt   (meas_cnt),
        .meas_sat   (meas_sat),
        .meas_go    (meas_go),
        .bias_code  (bias_code),
        .cap_sel    (cap_sel),
        .gbias_en   (gbias_en),
        .done       (done),
        .limit      (limit),
        .best_count (best_count)
    );
endmodule

// File: tb/bias_search_ctrl_bench.sv
// Scoreboard bench with a behavioural leaking-node model.
module bias_search_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       mode_chg = 1'b0;
    logic       node_in = 1'b1;
    logic       precharge;
    logic [1:0] cap_sel;
    logic       gbias_en;
    logic [3:0] bias_code;
    logic       done;
    logic       limit;
    logic [7:0] best_count;

    int checks = 0;
    int failures = 0;
    int scen = 1;
    int node_timer = 0;
    int pre_len = 0;
    int wd = 0;

    typedef struct {
        int code;
        bit lim;
        int cap;
        bit gb;
        int cnt;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    bias_search_ctrl u_bias_search_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_chg(mode_chg),
        .node_in(node_in), .precharge(precharge), .cap_sel(cap_sel),
        .gbias_en(gbias_en), .bias_code(bias_code), .done(done),
        .limit(limit), .best_count(best_count)
    );

    function automatic int base_of(int s, int c);
        case (s)
            1: base_of = (c <= 6) ? 40 + 12 * c : ((112 - 20 * (c - 6)) < 20 ? 20 : 112 - 20 * (c - 6));
            2: base_of = 40 + 12 * c;
            3: base_of = (c == 0) ? 3 : (c == 1) ? 20 : (c == 2) ? 40 : 30;
            default: base_of = (c <= 3) ? 600 + 40 * c : 560;
        endcase
    endfunction

    // Node flip time in cycles for the present outputs (R6 range encoding).
    function automatic int t_of(int s, int c, int cap, bit gb);
        int t;
        t = base_of(s, c) * (cap + 1);
        if (gb) t = t / 2;
        return t;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural monitor node: preset level while precharged, flips after T.
    always @(negedge clk) begin
        if (precharge) begin
            node_in    <= ~mode_chg;
            node_timer <= 0;
        end else begin
            if (node_timer >= t_of(scen, int'(bias_code), int'(cap_sel), gbias_en))
                node_in <= mode_chg;
            node_timer <= node_timer + 1;
        end
    end

    // R1: every precharge pulse lasts PRE_CYC cycles.
    always @(negedge clk) begin
        if (precharge) pre_len <= pre_len + 1;
        else if (pre_len != 0) begin
            check(pre_len == 4, "R1 precharge length", pre_len, 4);
            pre_len <= 0;
        end
    end

    // Scoreboard monitor: compare each search result with the expected item.
    always @(negedge clk) begin
        if (done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R10 unexpected done", 1, 0);
            end else begin
                exp_t e;
                int d;
                e = sb_q.pop_front();
                check(int'(bias_code) == e.code, "R5 optimum code", bias_code, e.code);
                check(limit == e.lim, "R9 limit flag", limit, e.lim);
                check(int'(cap_sel) == e.cap, "R6 R7 cap select", cap_sel, e.cap);
                check(gbias_en == e.gb, "R6 gate boost", gbias_en, e.gb);
                d = int'(best_count) - e.cnt;
                check(d >= -3 && d <= 3, "R2 best count", best_count, e.cnt);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            check(1'b0, "watchdog", wd, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Driver: computes the expected optimum independently and runs a search.
    task automatic run_search(input int s, input bit m, input int cap, input bit gb, input bit poke);
        exp_t e;
        int c;
        scen = s;
        mode_chg = m;
        e.code = 15;
        e.lim = 1'b1;
        for (int k = 1; k <= 15; k++) begin
            if (base_of(s, k) < base_of(s, k - 1)) begin
                e.code = k - 1;
                e.lim = 1'b0;
                break;
            end
        end
        c = e.code;
        e.cap = cap;
        e.gb = gb;
        e.cnt = t_of(s, c, cap, gb) / 2;
        sb_q.push_back(e);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (poke) begin
            repeat (300) @(negedge clk);
            start = 1'b1;            // R10: ignored while searching
            @(negedge clk) start = 1'b0;
        end
        while (sb_q.size() != 0) @(negedge clk);
        // R10: results held and no further done until the next start.
        repeat (40) @(negedge clk);
        check(int'(bias_code) == e.code, "R10 code held", bias_code, e.code);
        check(int'(cap_sel) == e.cap, "R10 range held", cap_sel, e.cap);
        check(!precharge, "R10 idle after done", precharge, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state.
        check(!precharge, "R11 precharge", precharge, 0);
        check(!done, "R11 done", done, 0);
        check(!limit, "R11 limit", limit, 0);
        check(best_count == 0, "R11 best_count", best_count, 0);
        check(bias_code == 0, "R11 bias_code", bias_code, 0);
        check(cap_sel == 2 && !gbias_en, "R11 range", cap_sel, 2);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        run_search(1, 1'b0, 2, 1'b0, 1'b1);  // R4 R5 discharge peak
        run_search(2, 1'b1, 1, 1'b0, 1'b0);  // R3 R8 R9 charge mode, restart
        run_search(3, 1'b0, 3, 1'b0, 1'b0);  // R7 too fast, slower range
        run_search(4, 1'b1, 0, 1'b1, 1'b0);  // R6 saturation up to gate boost
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule